// File: doc/BRIEF.md
# Access-Activity Power-Down Monitor

This block watches the control, address and data inputs of a memory array on every clock and decides whether the array should be in its high-power active state or in low-power standby. The block itself holds no memory. It only models the power behaviour of the array that sits next to it. All of its inputs are taken to be synchronous to the clock already.

An access-activity event wakes the array. Which events count depends on the enables and the write strobe at that moment. An event reloads a down-counter with a programmed delay in cycles. The array stays active until that count runs out with no further event. Because of this, the time spent active depends only on how often events arrive, and not on how long the select stays asserted. If either enable goes inactive, the array drops to standby at once.

Each input is compared with its value registered on the previous clock. A detected event is reported as a one-cycle pulse.

Top module: `apd_monitor`

## Requirements
- R1: After reset `awake` and `wake_pulse` are 0, and they stay 0 while the inputs hold a deselected state.
- R2: A 1-to-0 change of `sel_n` while `sel_hi` is 1 is an event. The same change while `sel_hi` is 0 is not an event.
- R3: A 0-to-1 change of `sel_hi` while `sel_n` is 0 is an event. The same change while `sel_n` is 1 is not an event.
- R4: A 1-to-0 change of `wr_n` while the array is selected (`sel_n`=0 and `sel_hi`=1) is an event.
- R5: A change on any bit of `addr` while the array is selected is an event. An address change while deselected is not an event.
- R6: A change on any bit of `data` is an event only while the array is selected and `wr_n` is 0. With `wr_n`=1 it is ignored.
- R7: An event with `delay`=D>0 makes `awake` 1 for exactly D cycles, starting in the cycle after the event was sampled. `awake` then returns to 0 even if the array stays selected.
- R8: An event that arrives while the countdown is running reloads it. `awake` then stays 1 for D cycles counted from the new event.
- R9: `wake_pulse` is 1 for exactly one cycle per event, in the same cycle that `awake` rises. `awake` never rises without `wake_pulse`.
- R10: When either enable is inactive at a clock edge, `awake` is 0 after that edge.
- R11: An event with `delay`=0 produces `wake_pulse` but leaves `awake` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n | input | 1 | Active-low array enable |
| sel_hi | input | 1 | Active-high array enable |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | ADDR_W | Array address |
| data | input | DATA_W | Array write data |
| delay | input | CNT_W | Power-down delay in cycles |
| awake | output | 1 | 1 = active, 0 = standby |
| wake_pulse | output | 1 | One-cycle event indication |

## Verification
The bench tests each enable edge twice: once with the other enable active and once with it inactive. A design that ignored the gating would wake on a one-sided select.

Data changes are tried both with the write strobe high and with it low. A design that treated data like address would wake during reads.

The bench also holds the select asserted past the delay. A design tied to select width would stay awake there.

Finally it fires a second event in the middle of a countdown and uses a zero delay. A design without reload would drop early, and an off-by-one counter would give a zero delay a phantom active cycle.

// File: rtl/apd_monitor.sv
module apd_monitor #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sel_hi,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic [CNT_W-1:0]  delay,
  output logic              awake,
  output logic              wake_pulse
);

  logic              sel_n_q, sel_hi_q, wr_n_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  cnt;

  wire selected = !sel_n && sel_hi;
  wire ev_lo    = !sel_n && sel_n_q && sel_hi;
  wire ev_hi    = sel_hi && !sel_hi_q && !sel_n;
  wire ev_wr    = selected && !wr_n && wr_n_q;
  wire ev_addr  = selected && (addr != addr_q);
  wire ev_data  = selected && !wr_n && (data != data_q);
  wire event_now = ev_lo | ev_hi | ev_wr | ev_addr | ev_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_n_q  <= 1'b1;
      sel_hi_q <= 1'b0;
      wr_n_q   <= 1'b1;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      sel_n_q  <= sel_n;
      sel_hi_q <= sel_hi;
      wr_n_q   <= wr_n;
      addr_q   <= addr;
      data_q   <= data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      wake_pulse <= 1'b0;
    end else begin
      wake_pulse <= event_now;
      if (event_now)      cnt <= delay;
      else if (!selected) cnt <= '0;
      else if (cnt != 0)  cnt <= cnt - 1'b1;
    end
  end

  assign awake = (cnt != 0);

  assert_rise_needs_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(awake) |-> wake_pulse);

  assert_deselect_standby_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!selected) |-> !awake);

  assert_event_loads_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> cnt == $past(delay));

  assert_countdown_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_pulse && $past(selected) && $past(cnt) != 0) |-> (cnt + 1'b1 == $past(cnt)));

  assert_zero_delay_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_pulse && $past(delay) == 0) |-> !awake);

endmodule

// File: tb/apd_monitor_tb.sv
module apd_monitor_tb;
  localparam int AW = 17, DW = 8, CW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_n = 1'b1, sel_hi = 1'b0, wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic [CW-1:0] delay = 8'd4;
  logic awake, wake_pulse;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  apd_monitor #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel_hi(sel_hi), .wr_n(wr_n),
    .addr(addr), .data(data), .delay(delay), .awake(awake), .wake_pulse(wake_pulse));

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit act, input bit exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", what, act, exp);
    end
  endtask

  task automatic deselect_idle();
    sel_n = 1'b1; sel_hi = 1'b0; wr_n = 1'b1;
    tick(); tick();
  endtask

  task automatic t_reset();
    tick();
    chk(awake, 0, "R1 awake in reset");
    rst_n = 1'b1;
    tick(); tick();
    chk(awake, 0, "R1 awake idle after reset");
    chk(wake_pulse, 0, "R1 pulse idle after reset");
  endtask

  task automatic t_lo_edge();
    delay = 8'd4;
    sel_n = 1'b0; tick();
    chk(wake_pulse, 0, "R2 sel_n fall with sel_hi low pulse");
    chk(awake, 0, "R2 sel_n fall with sel_hi low awake");
    deselect_idle();
    sel_hi = 1'b1; tick(); tick();
    sel_n = 1'b0; tick();
    chk(wake_pulse, 1, "R2 sel_n fall with sel_hi high pulse");
    chk(awake, 1, "R9 awake rises with pulse");
    tick();
    chk(wake_pulse, 0, "R9 pulse one cycle");
    tick(); tick();
    chk(awake, 1, "R7 awake in last active cycle");
    tick();
    chk(awake, 0, "R7 standby after delay with select held");
    tick(); tick();
    chk(awake, 0, "R7 stays standby while selected");
    deselect_idle();
  endtask

  task automatic t_hi_edge();
    sel_hi = 1'b1; tick();
    chk(wake_pulse, 0, "R3 sel_hi rise with sel_n high");
    deselect_idle();
    sel_n = 1'b0; tick(); tick();
    sel_hi = 1'b1; tick();
    chk(wake_pulse, 1, "R3 sel_hi rise with sel_n low pulse");
    chk(awake, 1, "R3 sel_hi rise awake");
    tick();
    sel_hi = 1'b0; tick();
    chk(awake, 0, "R10 deselect forces standby");
    deselect_idle();
  endtask

  task automatic t_write_addr();
    delay = 8'd3;
    sel_hi = 1'b1; tick();
    sel_n = 1'b0; tick();
    repeat (4) tick();
    chk(awake, 0, "R7 expired before write test");
    wr_n = 1'b0; tick();
    chk(wake_pulse, 1, "R4 wr_n fall while selected");
    wr_n = 1'b1;
    repeat (4) tick();
    addr = 17'h10000; tick();
    chk(wake_pulse, 1, "R5 address change while selected");
    repeat (4) tick();
    deselect_idle();
    wr_n = 1'b0; addr = 17'h00003; tick();
    chk(wake_pulse, 0, "R5 R4 changes while deselected");
    chk(awake, 0, "R10 deselected changes stay standby");
    deselect_idle();
  endtask

  task automatic t_data();
    delay = 8'd2;
    sel_hi = 1'b1; tick();
    sel_n = 1'b0; tick();
    repeat (3) tick();
    data = 8'h5A; tick();
    chk(wake_pulse, 0, "R6 data change with wr_n high pulse");
    chk(awake, 0, "R6 data change with wr_n high awake");
    wr_n = 1'b0; tick();
    repeat (3) tick();
    chk(awake, 0, "R6 expired before write data");
    data = 8'h80; tick();
    chk(wake_pulse, 1, "R6 data change during write");
    deselect_idle();
  endtask

  task automatic t_reload();
    delay = 8'd4;
    sel_hi = 1'b1; tick();
    sel_n = 1'b0; tick();
    tick(); tick();
    addr = 17'h00100; tick();
    chk(wake_pulse, 1, "R8 second event pulse");
    tick(); tick(); tick();
    chk(awake, 1, "R8 reloaded count still active");
    tick();
    chk(awake, 0, "R8 standby D cycles after reload");
    deselect_idle();
  endtask

  task automatic t_zero();
    delay = 8'd0;
    sel_hi = 1'b1; tick();
    sel_n = 1'b0; tick();
    chk(wake_pulse, 1, "R11 zero delay pulse");
    chk(awake, 0, "R11 zero delay no active");
    deselect_idle();
  endtask

  initial begin
    t_reset();
    t_lo_edge();
    t_hi_edge();
    t_write_addr();
    t_data();
    t_reload();
    t_zero();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule